// File: doc/BRIEF.md
# Stop-Pin Clock Gating Controller

This block decides, output by output, whether a running clock is passed through or parked at a safe level. It serves seven PCI clock outputs, three PCI outputs that can be made free-running, and three differential CPU pairs. The sources are two active-low stop pins, one for the PCI group and one for the CPU group, plus register-held bits from the rest of the chip: a software PCI-run bit, an enable bit per output, a stoppable mask for the free-run-capable PCI outputs, and a free-run mask for the CPU pairs.

The block runs on one oversampling clock `clk`. The running PCI and CPU clocks arrive as sampled levels on `pci_src` and `cpu_src`. Each output is a gate cell that follows its source one cycle late while running. A gate cell parks only on the source edge that moves toward its parked level, and it resumes only on the edge that moves away from it, so no high or low phase is ever cut short. Single-ended outputs park low. A differential pair parks with its true output high and its complement undriven. The package holds the power-up values that the register file is expected to use: PCI and free-run-capable PCI outputs enabled, CPU pairs not free-running.

Top module: `stopclk_gate`

## Requirements
- R1: PCI stop is active when `pci_stop_n`, after a two-flop synchronizer, is low, or when `sw_pci_run` is 0. Either source alone is enough.
- R2: While PCI stop is active, every `pci_out` bit parks at 0. It enters the parked state only on a falling edge of `pci_src`.
- R3: While PCI stop is active, `pcif_out[j]` parks at 0 when `pcif_stoppable[j]` is 1. It keeps toggling when that bit is 0.
- R4: While `cpu_stop_n`, after a two-flop synchronizer, is low, each pair k with `cpu_free[k]`=0 parks with `cpu_t[k]`=1, `cpu_c[k]`=0 and `cpu_c_oe[k]`=0. It enters the parked state only on a rising edge of `cpu_src`.
- R5: A pair with `cpu_free[k]`=1 and `cpu_en[k]`=1 keeps toggling while CPU stop is active.
- R6: An enable bit of 0 (`pci_en`, `pcif_en`, `cpu_en`) parks that output whatever the stop pins are doing. Single-ended outputs park low. Pairs park with true high and complement undriven.
- R7: A parked output resumes only on the source edge that leaves its parked level. The first PCI high phase after release therefore lasts the full 4 cycles of `pci_src`, and the first CPU true low phase lasts the full 2 cycles of `cpu_src`.
- R8: A running single-ended output equals its source as it was one `clk` cycle earlier. A running pair has `cpu_t` equal to the delayed `cpu_src`, `cpu_c` equal to its inverse, and `cpu_c_oe`=1.
- R9: During reset and in the first cycle after it, all outputs sit at their parked levels: `pci_out`=0, `pcif_out`=0, `cpu_t`=all ones, `cpu_c`=0, `cpu_c_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pci_stop_n | input | 1 | PCI stop pin, active low, asynchronous |
| cpu_stop_n | input | 1 | CPU stop pin, active low, asynchronous |
| sw_pci_run | input | 1 | Software PCI run bit; 0 requests PCI stop |
| pci_en | input | NUM_PCI | Per-output enable, PCI group |
| pcif_en | input | NUM_PCIF | Per-output enable, free-run-capable PCI group |
| pcif_stoppable | input | NUM_PCIF | 1: output obeys PCI stop |
| cpu_en | input | NUM_CPU | Per-pair enable |
| cpu_free | input | NUM_CPU | 1: pair ignores CPU stop |
| pci_src | input | 1 | Sampled running PCI clock |
| cpu_src | input | 1 | Sampled running CPU clock |
| pci_out | output | NUM_PCI | Gated PCI clocks |
| pcif_out | output | NUM_PCIF | Gated free-run-capable PCI clocks |
| cpu_t | output | NUM_CPU | Gated CPU true outputs |
| cpu_c | output | NUM_CPU | Gated CPU complement outputs |
| cpu_c_oe | output | NUM_CPU | Complement drive enable; 0 means undriven |

## Verification
Some properties can be checked on every cycle, and the assertions cover those. A rising PCI output must follow a low-then-high source, so no high phase is truncated. A falling CPU true output must follow a high-then-low source. A running output may only show a level its source held the cycle before. A pair with its complement undriven must show true high. A free-running, enabled pair must never park. Other behaviours depend on which stop source and which mask produced the park, and only the bench's scenarios show those. These are the OR of the pin and the software bit, the stoppable and free-run masks, the enable-driven park, the full-width first phase after release, and the reset state.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;
    localparam int N_PCI  = 7;
    localparam int N_PCIF = 3;
    localparam int N_CPU  = 3;

    // Power-up values expected from the register file
    localparam logic [N_PCI-1:0]  PCI_EN_PWRUP   = '1;
    localparam logic [N_PCIF-1:0] PCIF_EN_PWRUP  = '1;
    localparam logic [N_CPU-1:0]  CPU_FREE_PWRUP = '0;

    typedef enum logic {
        GATE_PARKED  = 1'b0,
        GATE_RUNNING = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic toward;   // source edge moving to the parked level
        logic away;     // source edge leaving the parked level
    } src_edge_s;

    function automatic src_edge_s classify_edge(logic prev, logic cur, logic park_hi);
        src_edge_s e;
        logic rise;
        logic fall;
        rise = !prev && cur;
        fall = prev && !cur;
        e.toward = park_hi ? rise : fall;
        e.away   = park_hi ? fall : rise;
        return e;
    endfunction
endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/stopclk_gate_cell.sv
module stopclk_gate_cell
    import stopclk_pkg::*;
#(
    parameter logic PARK_HI = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic src,
    output logic lvl,
    output logic running
);
    logic        src_q;
    logic        primed;
    gate_state_e st, st_n;
    src_edge_s   e;

    always_comb begin
        e    = classify_edge(src_q, src, PARK_HI);
        st_n = st;
        if (primed) begin
            if (st == GATE_RUNNING && req && e.toward)
                st_n = GATE_PARKED;
            else if (st == GATE_PARKED && !req && e.away)
                st_n = GATE_RUNNING;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= 1'b0;
            primed <= 1'b0;
            st     <= GATE_PARKED;
            lvl    <= PARK_HI;
        end else begin
            src_q  <= src;
            primed <= 1'b1;
            st     <= st_n;
            lvl    <= (st_n == GATE_RUNNING) ? src : PARK_HI;
        end
    end

    assign running = (st == GATE_RUNNING);
endmodule

// File: rtl/stopclk_gate.sv
module stopclk_gate
    import stopclk_pkg::*;
#(
    parameter int NUM_PCI     = N_PCI,
    parameter int NUM_PCIF    = N_PCIF,
    parameter int NUM_CPU     = N_CPU,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pci_stop_n,
    input  logic                cpu_stop_n,
    input  logic                sw_pci_run,
    input  logic [NUM_PCI-1:0]  pci_en,
    input  logic [NUM_PCIF-1:0] pcif_en,
    input  logic [NUM_PCIF-1:0] pcif_stoppable,
    input  logic [NUM_CPU-1:0]  cpu_en,
    input  logic [NUM_CPU-1:0]  cpu_free,
    input  logic                pci_src,
    input  logic                cpu_src,
    output logic [NUM_PCI-1:0]  pci_out,
    output logic [NUM_PCIF-1:0] pcif_out,
    output logic [NUM_CPU-1:0]  cpu_t,
    output logic [NUM_CPU-1:0]  cpu_c,
    output logic [NUM_CPU-1:0]  cpu_c_oe
);
    logic pci_stop_n_s, cpu_stop_n_s;
    logic pci_halt, cpu_halt;

    stopclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pci (
        .clk(clk), .rst(rst), .d(pci_stop_n), .q(pci_stop_n_s));
    stopclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cpu (
        .clk(clk), .rst(rst), .d(cpu_stop_n), .q(cpu_stop_n_s));

    assign pci_halt = !pci_stop_n_s || !sw_pci_run;
    assign cpu_halt = !cpu_stop_n_s;

    for (genvar i = 0; i < NUM_PCI; i++) begin : g_pci
        logic run_unused;
        stopclk_gate_cell #(.PARK_HI(1'b0)) u_cell (
            .clk(clk), .rst(rst),
            .req(pci_halt || !pci_en[i]),
            .src(pci_src), .lvl(pci_out[i]), .running(run_unused));
    end

    for (genvar j = 0; j < NUM_PCIF; j++) begin : g_pcif
        logic run_unused;
        stopclk_gate_cell #(.PARK_HI(1'b0)) u_cell (
            .clk(clk), .rst(rst),
            .req((pci_halt && pcif_stoppable[j]) || !pcif_en[j]),
            .src(pci_src), .lvl(pcif_out[j]), .running(run_unused));
    end

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
        logic run_k;
        stopclk_gate_cell #(.PARK_HI(1'b1)) u_cell (
            .clk(clk), .rst(rst),
            .req((cpu_halt && !cpu_free[k]) || !cpu_en[k]),
            .src(cpu_src), .lvl(cpu_t[k]), .running(run_k));
        assign cpu_c[k]    = run_k && !cpu_t[k];
        assign cpu_c_oe[k] = run_k;
    end
endmodule

// File: rtl/stopclk_gate_chk.sv
module stopclk_gate_chk #(
    parameter int NUM_PCI  = 7,
    parameter int NUM_PCIF = 3,
    parameter int NUM_CPU  = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                pci_src,
    input logic                cpu_src,
    input logic [NUM_CPU-1:0]  cpu_en,
    input logic [NUM_CPU-1:0]  cpu_free,
    input logic [NUM_PCI-1:0]  pci_out,
    input logic [NUM_PCIF-1:0] pcif_out,
    input logic [NUM_CPU-1:0]  cpu_t,
    input logic [NUM_CPU-1:0]  cpu_c,
    input logic [NUM_CPU-1:0]  cpu_c_oe
);
    for (genvar i = 0; i < NUM_PCI; i++) begin : g_pci
        AST_PCI_TRACKS_SRC: assert property (@(posedge clk) disable iff (rst)
            pci_out[i] |-> $past(pci_src)); // R8
        AST_PCI_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
            $rose(pci_out[i]) |-> !$past(pci_src, 2)); // R7
    end

    for (genvar j = 0; j < NUM_PCIF; j++) begin : g_pcif
        AST_PCIF_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
            $rose(pcif_out[j]) |-> !$past(pci_src, 2)); // R7
    end

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
        AST_CPU_PARK_LEVEL: assert property (@(posedge clk) disable iff (rst)
            !cpu_c_oe[k] |-> (cpu_t[k] && !cpu_c[k])); // R4
        AST_CPU_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
            cpu_c_oe[k] |-> (cpu_c[k] != cpu_t[k])); // R8
        AST_CPU_FULL_LOW: assert property (@(posedge clk) disable iff (rst)
            $fell(cpu_t[k]) |-> $past(cpu_src, 2)); // R7
        AST_CPU_FREE_NO_PARK: assert property (@(posedge clk) disable iff (rst)
            $fell(cpu_c_oe[k]) |-> !($past(cpu_free[k]) && $past(cpu_en[k]))); // R5
    end
endmodule

bind stopclk_gate stopclk_gate_chk #(
    .NUM_PCI(NUM_PCI), .NUM_PCIF(NUM_PCIF), .NUM_CPU(NUM_CPU)
) u_chk (
    .clk(clk), .rst(rst), .pci_src(pci_src), .cpu_src(cpu_src),
    .cpu_en(cpu_en), .cpu_free(cpu_free),
    .pci_out(pci_out), .pcif_out(pcif_out),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_c_oe(cpu_c_oe)
);

// File: tb/stopclk_gate_test.sv
module stopclk_gate_test;
    import stopclk_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pci_stop_n = 1'b1, cpu_stop_n = 1'b1, sw_pci_run = 1'b1;
    logic [N_PCI-1:0]  pci_en = PCI_EN_PWRUP;
    logic [N_PCIF-1:0] pcif_en = PCIF_EN_PWRUP;
    logic [N_PCIF-1:0] pcif_stoppable = '0;
    logic [N_CPU-1:0]  cpu_en = '1;
    logic [N_CPU-1:0]  cpu_free = CPU_FREE_PWRUP;
    logic pci_src = 1'b0, cpu_src = 1'b0;
    logic [N_PCI-1:0]  pci_out;
    logic [N_PCIF-1:0] pcif_out;
    logic [N_CPU-1:0]  cpu_t, cpu_c, cpu_c_oe;

    int n_checks = 0;
    int n_errors = 0;
    int phase_cnt = 0;

    // observation record
    logic [N_PCI-1:0]  or_pci;
    logic [N_PCIF-1:0] or_pcif;
    logic [N_CPU-1:0]  and_t, or_oe, or_c;
    int tog_pci[N_PCI];
    int tog_pcif[N_PCIF];
    int tog_cpu[N_CPU];

    always #5 clk = ~clk;

    // PCI source: 4 high / 4 low; CPU source: 2 high / 2 low; updated 3 ns after the edge
    always @(posedge clk) begin
        #3;
        phase_cnt <= phase_cnt + 1;
        pci_src   <= phase_cnt[2];
        cpu_src   <= phase_cnt[1];
    end

    stopclk_gate uut (
        .clk(clk), .rst(rst), .pci_stop_n(pci_stop_n), .cpu_stop_n(cpu_stop_n),
        .sw_pci_run(sw_pci_run), .pci_en(pci_en), .pcif_en(pcif_en),
        .pcif_stoppable(pcif_stoppable), .cpu_en(cpu_en), .cpu_free(cpu_free),
        .pci_src(pci_src), .cpu_src(cpu_src), .pci_out(pci_out),
        .pcif_out(pcif_out), .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_c_oe(cpu_c_oe));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic observe(input int n);
        logic [N_PCI-1:0]  pp;
        logic [N_PCIF-1:0] pf;
        logic [N_CPU-1:0]  pt;
        or_pci = '0; or_pcif = '0; and_t = '1; or_oe = '0; or_c = '0;
        for (int i = 0; i < N_PCI; i++)  tog_pci[i] = 0;
        for (int i = 0; i < N_PCIF; i++) tog_pcif[i] = 0;
        for (int i = 0; i < N_CPU; i++)  tog_cpu[i] = 0;
        @(negedge clk);
        pp = pci_out; pf = pcif_out; pt = cpu_t;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            or_pci |= pci_out; or_pcif |= pcif_out;
            and_t &= cpu_t; or_oe |= cpu_c_oe; or_c |= cpu_c;
            for (int i = 0; i < N_PCI; i++)  if (pci_out[i] != pp[i]) tog_pci[i]++;
            for (int i = 0; i < N_PCIF; i++) if (pcif_out[i] != pf[i]) tog_pcif[i]++;
            for (int i = 0; i < N_CPU; i++)  if (cpu_t[i] != pt[i]) tog_cpu[i]++;
            pp = pci_out; pf = pcif_out; pt = cpu_t;
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        wait_cycles(4);
        chk(pci_out == '0 && pcif_out == '0, "R9", "single-ended in reset",
            int'({pcif_out, pci_out}), 0);
        chk(cpu_t == '1 && cpu_c == '0 && cpu_c_oe == '0, "R9", "pairs in reset",
            int'({cpu_t, cpu_c, cpu_c_oe}), 9'h1C0);
        rst = 1'b0;
        @(negedge clk);
        chk(pci_out == '0 && cpu_t == '1 && cpu_c_oe == '0, "R9", "first cycle after reset",
            int'({pci_out, cpu_t, cpu_c_oe}), int'({7'h0, 3'h7, 3'h0}));
    endtask

    task automatic test_running();
        int bad_pci = 0, bad_cpu = 0;
        logic ps, cs;
        wait_cycles(20);
        ps = pci_src; cs = cpu_src;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            if (pci_out != {N_PCI{ps}} || pcif_out != {N_PCIF{ps}}) bad_pci++;
            if (cpu_t != {N_CPU{cs}} || cpu_c != {N_CPU{~cs}} || cpu_c_oe != '1) bad_cpu++;
            ps = pci_src; cs = cpu_src;
        end
        chk(bad_pci == 0, "R8", "single-ended follow source by one cycle", bad_pci, 0);
        chk(bad_cpu == 0, "R8", "pairs follow source with inverse complement", bad_cpu, 0);
    endtask

    task automatic test_pci_pin_stop();
        int len = 0;
        pcif_stoppable = 3'b101;
        pci_stop_n = 1'b0;
        wait_cycles(20);
        observe(24);
        chk(or_pci == '0, "R2", "PCI outputs parked low by pin", int'(or_pci), 0);
        chk(or_pcif[0] == 0 && or_pcif[2] == 0, "R3", "stoppable free-run-capable parked",
            int'(or_pcif), 2);
        chk(tog_pcif[1] > 0, "R3", "non-stoppable output keeps running", tog_pcif[1], 6);
        chk(tog_cpu[0] > 0, "R1", "CPU pair unaffected by PCI stop", tog_cpu[0], 12);
        pci_stop_n = 1'b1;
        for (int c = 0; c < 40 && pci_out[0] == 1'b0; c++) @(negedge clk);
        while (pci_out[0] == 1'b1 && len < 20) begin len++; @(negedge clk); end
        chk(len == 4, "R7", "first PCI high phase after release", len, 4);
        pcif_stoppable = '0;
    endtask

    task automatic test_sw_stop();
        pcif_stoppable = 3'b010;
        sw_pci_run = 1'b0;
        wait_cycles(20);
        observe(24);
        chk(or_pci == '0, "R1", "software bit parks PCI outputs", int'(or_pci), 0);
        chk(or_pcif[1] == 0 && tog_pcif[0] > 0, "R3", "mask selects parked outputs under software stop",
            int'(or_pcif), 5);
        sw_pci_run = 1'b1;
        wait_cycles(20);
        observe(16);
        chk(tog_pci[3] > 0, "R1", "PCI resumes when software bit returns to 1", tog_pci[3], 4);
        pcif_stoppable = '0;
    endtask

    task automatic test_cpu_stop();
        int len = 0;
        cpu_free = 3'b010;
        cpu_stop_n = 1'b0;
        wait_cycles(20);
        observe(24);
        chk(and_t[0] && and_t[2] && !or_oe[0] && !or_oe[2] && !or_c[0] && !or_c[2], "R4",
            "stoppable pairs park true high, complement undriven",
            int'({and_t, or_oe, or_c}), int'({3'b101, 3'b010, 3'b010}));
        chk(tog_cpu[1] > 0 && or_oe[1], "R5", "free-running pair ignores CPU stop", tog_cpu[1], 12);
        chk(tog_pci[0] > 0, "R4", "PCI outputs unaffected by CPU stop", tog_pci[0], 6);
        cpu_stop_n = 1'b1;
        for (int c = 0; c < 40 && cpu_t[0] == 1'b1; c++) @(negedge clk);
        while (cpu_t[0] == 1'b0 && len < 20) begin len++; @(negedge clk); end
        chk(len == 2, "R7", "first CPU low phase after release", len, 2);
        cpu_free = CPU_FREE_PWRUP;
    endtask

    task automatic test_enables();
        pci_en = 7'b1111110;
        pcif_en = 3'b011;
        cpu_en = 3'b110;
        cpu_free = '1;
        wait_cycles(20);
        observe(24);
        chk(or_pci[0] == 0 && tog_pci[1] > 0, "R6", "disabled PCI output parks low",
            int'(or_pci), 126);
        chk(or_pcif[2] == 0 && tog_pcif[0] > 0, "R6", "disabled free-run-capable output parks low",
            int'(or_pcif), 3);
        chk(and_t[0] && !or_oe[0] && tog_cpu[1] > 0, "R6", "disabled pair parks true high, complement off",
            int'({and_t[0], or_oe[0]}), 2);
        pci_en = PCI_EN_PWRUP; pcif_en = PCIF_EN_PWRUP; cpu_en = '1; cpu_free = CPU_FREE_PWRUP;
        wait_cycles(20);
        observe(16);
        chk(tog_pci[0] > 0 && tog_cpu[0] > 0, "R6", "re-enabled outputs run again", tog_pci[0], 4);
    endtask

    initial begin
        fork
            begin
                test_reset();
                test_running();
                test_pci_pin_stop();
                test_sw_stop();
                test_cpu_stop();
                test_enables();
            end
            begin
                wait_cycles(20000);
                chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule